// File: doc/BRIEF.md
# Two-Port Display Controller Host Interface

This block is the processor-facing front end of a tile-based display controller. The host sees two byte-wide ports, selected by one address bit: a data port and a command port. The data port reads and writes a 16 KB video memory through a 14-bit pointer. The pointer advances by one after every access and wraps from 3FFFh to 0000h. The command port accepts two-byte commands and returns a status byte. A command either loads the pointer, for later reads or for later writes, or writes one of 47 write-only control registers.

One byte latch is shared by three users. It holds the first byte of a command, the last byte written to the data port, and the byte fetched ahead of the next data-port read. Reads are served from that latch, so the host never waits for memory. The memory interface is a one-cycle request with a write enable. Read data comes back on the clock edge after the request. Three status flags (end of frame, fifth sprite on a line, sprite collision) are set by one-cycle pulses from the renderer. A status read clears them. An interrupt line follows the frame flag, gated by an enable bit in register 1.

Top module: `dpc_host_if`

## Requirements
- R1: A data-port write (host_sel=1, host_cmd=0, host_wr=1) produces, on the next cycle, a one-cycle vram_req with vram_we=1, vram_addr equal to the pointer and vram_wdata equal to the byte. The pointer then advances by one, wrapping at 14 bits. The byte is also loaded into the shared latch.
- R2: A data-port read puts the latch on host_rdata after the edge on which it is sampled. It also issues a memory read of the pointer and advances the pointer by one. The returned byte enters the latch two edges after the access. Host accesses are spaced at least four idle cycles apart.
- R3: A command-port write alternates between first byte and second byte. A first byte is loaded into the shared latch. A data-port access or a status read sends the sequence back to "first byte", so a command broken this way is dropped.
- R4: A second byte with bits 7:6 = 10 copies the first byte into control register bits 5:0, provided that register number is below 47. A larger number changes no register.
- R5: A second byte with bits 7:6 = 00 sets the pointer to {second[5:0], first}. It then fetches that byte into the latch and leaves the pointer at that address plus one.
- R6: A second byte with bits 7:6 = 01 or 11 sets the pointer to {second[5:0], first} and fetches nothing. The latch keeps the first byte.
- R7: A status read (host_sel=1, host_cmd=1, host_wr=0) returns the following byte: bit 7 is the frame flag, bit 6 the fifth-sprite flag, bit 5 the collision flag, and bits 4:0 the fifth-sprite number.
- R8: A status read clears the three flags and keeps the sprite number. A set pulse in the same cycle as the read keeps that flag set.
- R9: The fifth-sprite number is captured from fifth_id on a fifth-sprite pulse only while that flag is clear.
- R10: irq equals the frame flag AND bit 5 of control register 1.
- R11: After reset, the pointer, latch, host_rdata, flags, registers, irq and vram_req are all zero, and the sequence expects a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | One-cycle host access strobe |
| host_cmd | input | 1 | 1 = command port, 0 = data port |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| vram_req | output | 1 | Video memory request |
| vram_we | output | 1 | Request is a write |
| vram_addr | output | 14 | Video memory address |
| vram_wdata | output | 8 | Video memory write byte |
| vram_rdata | input | 8 | Video memory read byte, valid the cycle after a request |
| flag_frame_set | input | 1 | Pulse that sets the frame flag |
| flag_fifth_set | input | 1 | Pulse that sets the fifth-sprite flag |
| fifth_id | input | 5 | Sprite number sent with the fifth-sprite pulse |
| flag_coll_set | input | 1 | Pulse that sets the collision flag |
| ctrl_regs | output | 376 | Control registers, register n in bits 8n+7:8n |
| irq | output | 1 | Interrupt request |

## Verification
A pointer that is off by one shows up on the next data-port read. That read returns a byte one address away from the expected one, and the following vram_addr is wrong as well. A command sequence stuck on the wrong byte is visible at once: the next command register write lands in the wrong register, or the pointer loads the wrong address. A latch overwritten at the wrong time shows on the next data read. A flag that is not cleared, or is cleared too eagerly, shows on the very next status read and on irq.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    CMD_PTR_RD  = 2'b00,
    CMD_PTR_WR  = 2'b01,
    CMD_REG_WR  = 2'b10,
    CMD_PTR_WR2 = 2'b11
  } cmd_mode_e;

  typedef struct packed {
    logic       frame;
    logic       fifth;
    logic       coll;
    logic [4:0] num;
  } status_t;
endpackage

// File: rtl/dpc_cmd_seq.sv
module dpc_cmd_seq #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              other_acc,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] first_byte,
  output logic              second_q,
  output logic              first_load,
  output logic              reg_we,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              ptr_load,
  output logic              ptr_prefetch,
  output logic [ADDR_W-1:0] ptr_addr
);
  import dpc_pkg::*;
  localparam int HI_W = ADDR_W - DATA_W;

  cmd_mode_e mode;
  logic      second_now;

  always_ff @(posedge clk) begin
    if (rst)            second_q <= 1'b0;
    else if (cmd_wr)    second_q <= ~second_q;
    else if (other_acc) second_q <= 1'b0;
  end

  always_comb begin
    mode         = cmd_mode_e'(wdata[DATA_W-1 -: 2]);
    second_now   = cmd_wr & second_q;
    first_load   = cmd_wr & ~second_q;
    reg_we       = second_now && (mode == CMD_REG_WR);
    ptr_load     = second_now && (mode != CMD_REG_WR);
    ptr_prefetch = second_now && (mode == CMD_PTR_RD);
    reg_idx      = wdata[IDX_W-1:0];
    ptr_addr     = {wdata[HI_W-1:0], first_byte};
  end
endmodule

// File: rtl/dpc_vram_port.sv
module dpc_vram_port #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              first_load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ptr_load,
  input  logic              ptr_prefetch,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] latch_q,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic              fill_q;
  logic              issue;
  logic [ADDR_W-1:0] addr_now;

  always_comb begin
    issue    = data_wr | data_rd | ptr_prefetch;
    addr_now = ptr_load ? ptr_addr : ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      latch_q   <= '0;
      fill_q    <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req <= issue;
      mem_we  <= data_wr;
      fill_q  <= mem_req & ~mem_we;
      if (issue) begin
        mem_addr <= addr_now;
        ptr_q    <= addr_now + ADDR_W'(1);
      end else if (ptr_load) begin
        ptr_q <= ptr_addr;
      end
      if (data_wr) mem_wdata <= wdata;
      if (data_wr | first_load) latch_q <= wdata;
      else if (fill_q)          latch_q <= mem_rdata;
    end
  end
endmodule

// File: rtl/dpc_ctrl_regs.sv
module dpc_ctrl_regs #(
  parameter int NUM_REGS = 47,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DATA_W-1:0]          val,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_flat[g*DATA_W +: DATA_W] <= '0;
      else if (we && (idx == IDX_W'(g)))
        regs_flat[g*DATA_W +: DATA_W] <= val;
    end
  end
endmodule

// File: rtl/dpc_status.sv
module dpc_status (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic             set_frame,
  input  logic             set_fifth,
  input  logic             set_coll,
  input  logic [4:0]       fifth_id,
  output dpc_pkg::status_t stat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      stat_q.frame <= set_frame | (stat_q.frame & ~rd);
      stat_q.fifth <= set_fifth | (stat_q.fifth & ~rd);
      stat_q.coll  <= set_coll  | (stat_q.coll  & ~rd);
      if (set_fifth && !stat_q.fifth) stat_q.num <= fifth_id;
    end
  end
endmodule

// File: rtl/dpc_host_if.sv
module dpc_host_if #(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 47,
  parameter int IE_REG   = 1,
  parameter int IE_BIT   = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       host_sel,
  input  logic                       host_cmd,
  input  logic                       host_wr,
  input  logic [DATA_W-1:0]          host_wdata,
  output logic [DATA_W-1:0]          host_rdata,
  output logic                       vram_req,
  output logic                       vram_we,
  output logic [ADDR_W-1:0]          vram_addr,
  output logic [DATA_W-1:0]          vram_wdata,
  input  logic [DATA_W-1:0]          vram_rdata,
  input  logic                       flag_frame_set,
  input  logic                       flag_fifth_set,
  input  logic [4:0]                 fifth_id,
  input  logic                       flag_coll_set,
  output logic [NUM_REGS*DATA_W-1:0] ctrl_regs,
  output logic                       irq
);
  localparam int IDX_W = 6;

  logic              data_wr, data_rd, cmd_wr, stat_rd;
  logic              second_q, first_load, reg_we, ptr_load, ptr_prefetch;
  logic [IDX_W-1:0]  reg_idx;
  logic [ADDR_W-1:0] ptr_addr, ptr_q;
  logic [DATA_W-1:0] latch_q;
  dpc_pkg::status_t  stat_q;

  always_comb begin
    data_wr = host_sel & ~host_cmd &  host_wr;
    data_rd = host_sel & ~host_cmd & ~host_wr;
    cmd_wr  = host_sel &  host_cmd &  host_wr;
    stat_rd = host_sel &  host_cmd & ~host_wr;
  end

  dpc_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .other_acc(data_wr | data_rd | stat_rd),
    .wdata(host_wdata), .first_byte(latch_q), .second_q(second_q),
    .first_load(first_load), .reg_we(reg_we), .reg_idx(reg_idx),
    .ptr_load(ptr_load), .ptr_prefetch(ptr_prefetch), .ptr_addr(ptr_addr)
  );

  dpc_vram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .data_wr(data_wr), .data_rd(data_rd),
    .first_load(first_load), .wdata(host_wdata), .ptr_load(ptr_load),
    .ptr_prefetch(ptr_prefetch), .ptr_addr(ptr_addr), .mem_rdata(vram_rdata),
    .latch_q(latch_q), .ptr_q(ptr_q), .mem_req(vram_req), .mem_we(vram_we),
    .mem_addr(vram_addr), .mem_wdata(vram_wdata)
  );

  dpc_ctrl_regs #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .idx(reg_idx), .val(latch_q),
    .regs_flat(ctrl_regs)
  );

  dpc_status u_stat (
    .clk(clk), .rst(rst), .rd(stat_rd), .set_frame(flag_frame_set),
    .set_fifth(flag_fifth_set), .set_coll(flag_coll_set), .fifth_id(fifth_id),
    .stat_q(stat_q)
  );

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (data_rd) host_rdata <= latch_q;
    else if (stat_rd) host_rdata <= DATA_W'(stat_q);
  end

  assign irq = stat_q.frame & ctrl_regs[IE_REG*DATA_W + IE_BIT];
endmodule

// File: rtl/dpc_host_if_chk.sv
module dpc_host_if_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_sel,
  input logic              host_cmd,
  input logic              host_wr,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              vram_req,
  input logic              vram_we,
  input logic [ADDR_W-1:0] vram_addr,
  input logic [DATA_W-1:0] vram_wdata,
  input logic [ADDR_W-1:0] ptr_q,
  input logic              second_q,
  input logic              frame_q,
  input logic              flag_frame_set,
  input logic              irq
);
  logic d_wr, d_rd, s_rd;
  assign d_wr = host_sel & ~host_cmd &  host_wr;
  assign d_rd = host_sel & ~host_cmd & ~host_wr;
  assign s_rd = host_sel &  host_cmd & ~host_wr;

  p_write_req_r1: assert property (@(posedge clk) disable iff (rst)
    d_wr |=> vram_req && vram_we && vram_wdata == $past(host_wdata) && vram_addr == $past(ptr_q));

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    d_rd |=> ptr_q == $past(ptr_q) + ADDR_W'(1));

  p_seq_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (d_wr || d_rd || s_rd) |=> !second_q);

  p_status_frame_r7: assert property (@(posedge clk) disable iff (rst)
    s_rd |=> host_rdata[DATA_W-1] == $past(frame_q));

  p_frame_wins_r8: assert property (@(posedge clk) disable iff (rst)
    flag_frame_set |=> frame_q);

  p_irq_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (s_rd && !flag_frame_set) |=> !irq);
endmodule

bind dpc_host_if dpc_host_if_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .host_sel(host_sel), .host_cmd(host_cmd), .host_wr(host_wr),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .vram_req(vram_req),
  .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
  .ptr_q(ptr_q), .second_q(second_q), .frame_q(stat_q.frame),
  .flag_frame_set(flag_frame_set), .irq(irq)
);

// File: tb/dpc_host_if_test.sv
module dpc_host_if_test;
  localparam int NR = 47;

  logic         clk = 0, rst = 1;
  logic         host_sel = 0, host_cmd = 0, host_wr = 0;
  logic [7:0]   host_wdata = 0, host_rdata;
  logic         vram_req, vram_we;
  logic [13:0]  vram_addr;
  logic [7:0]   vram_wdata, vram_rdata = 0;
  logic         flag_frame_set = 0, flag_fifth_set = 0, flag_coll_set = 0;
  logic [4:0]   fifth_id = 0;
  logic [NR*8-1:0] ctrl_regs;
  logic         irq;

  int checks = 0, fails = 0;
  bit done = 0;

  dpc_host_if uut (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] fill(logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01};
  endfunction

  // memory model seen by the design
  logic [7:0] vmem [int];
  always @(posedge clk) begin
    if (vram_req) begin
      if (vram_we) vmem[int'(vram_addr)] = vram_wdata;
      else vram_rdata <= vmem.exists(int'(vram_addr)) ? vmem[int'(vram_addr)] : fill(vram_addr);
    end
  end

  // reference model
  logic [7:0]  m_mem [int];
  logic [13:0] m_ptr = 0;
  logic [7:0]  m_latch = 0;
  bit          m_second = 0;
  logic [7:0]  m_regs [NR];
  bit          m_frame = 0, m_fifth = 0, m_coll = 0;
  logic [4:0]  m_num = 0;

  function automatic logic [7:0] m_get(logic [13:0] a);
    return m_mem.exists(int'(a)) ? m_mem[int'(a)] : fill(a);
  endfunction

  function automatic logic [NR*8-1:0] m_pack();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = m_regs[i];
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [NR*8-1:0] act, logic [NR*8-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic gap();
    repeat (4) @(negedge clk);
    chk(irq == (m_frame & m_regs[1][5]), "R10", irq, m_frame & m_regs[1][5]);
  endtask

  task automatic data_wr(logic [7:0] b);
    @(negedge clk);
    host_sel = 1; host_cmd = 0; host_wr = 1; host_wdata = b;
    @(negedge clk);
    host_sel = 0;
    chk(vram_req && vram_we && vram_addr == m_ptr && vram_wdata == b, "R1",
        {vram_req, vram_we, vram_addr, vram_wdata}, {2'b11, m_ptr, b});
    m_mem[int'(m_ptr)] = b; m_latch = b; m_ptr++; m_second = 0;
    gap();
  endtask

  task automatic data_rd();
    logic [7:0] e;
    @(negedge clk);
    host_sel = 1; host_cmd = 0; host_wr = 0;
    @(negedge clk);
    host_sel = 0;
    e = m_latch;
    chk(host_rdata == e, "R2", host_rdata, e);
    m_latch = m_get(m_ptr); m_ptr++; m_second = 0;
    gap();
  endtask

  task automatic cmd_wr(logic [7:0] b);
    @(negedge clk);
    host_sel = 1; host_cmd = 1; host_wr = 1; host_wdata = b;
    @(negedge clk);
    host_sel = 0;
    if (!m_second) begin
      m_latch = b; m_second = 1;
    end else begin
      m_second = 0;
      if (b[7:6] == 2'b10) begin
        if (b[5:0] < NR) m_regs[b[5:0]] = m_latch;
      end else begin
        m_ptr = {b[5:0], m_latch};
        if (b[7:6] == 2'b00) begin m_latch = m_get(m_ptr); m_ptr++; end
      end
    end
    gap();
  endtask

  task automatic stat_rd(bit pf, string req);
    logic [7:0] e;
    @(negedge clk);
    host_sel = 1; host_cmd = 1; host_wr = 0; flag_frame_set = pf;
    @(negedge clk);
    host_sel = 0; flag_frame_set = 0;
    e = {m_frame, m_fifth, m_coll, m_num};
    chk(host_rdata == e, req, host_rdata, e);
    m_frame = pf; m_fifth = 0; m_coll = 0; m_second = 0;
    gap();
  endtask

  task automatic pulse(bit f, bit s, bit c, logic [4:0] n);
    @(negedge clk);
    flag_frame_set = f; flag_fifth_set = s; flag_coll_set = c; fifth_id = n;
    @(negedge clk);
    flag_frame_set = 0; flag_fifth_set = 0; flag_coll_set = 0;
    if (s && !m_fifth) m_num = n;
    m_frame |= f; m_fifth |= s; m_coll |= c;
    gap();
  endtask

  task automatic chk_regs(string req);
    chk(ctrl_regs == m_pack(), req, ctrl_regs, m_pack());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) m_regs[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(host_rdata == 0 && !vram_req && !irq, "R11", {host_rdata, vram_req, irq}, 0);
    chk_regs("R11");
    stat_rd(0, "R11");
    data_rd();                       // R11 latch zero, R2 fetch of address 0
    data_rd();                       // R2 returns byte at 0
    // R1 / R2 write then read back via R5
    cmd_wr(8'h00); cmd_wr(8'h41);    // R6 pointer 0100 for writes
    data_rd();                       // R6 latch still holds first byte 00
    cmd_wr(8'hFF); cmd_wr(8'h7F);    // R6 pointer 3FFF
    data_wr(8'hA5); data_wr(8'h5A);  // R1 wrap to 0000
    cmd_wr(8'hFF); cmd_wr(8'h3F);    // R5 read setup at 3FFF
    data_rd(); data_rd();            // R5 R2 A5 then 5A across wrap
    // R4 register writes
    cmd_wr(8'h20); cmd_wr(8'h81);    // reg1 = 20 enables irq
    chk_regs("R4");
    cmd_wr(8'h77); cmd_wr(8'hAE);    // reg 46
    chk_regs("R4");
    cmd_wr(8'h99); cmd_wr(8'hAF);    // reg 47 ignored
    chk_regs("R4");
    cmd_wr(8'h55); cmd_wr(8'hBF);    // reg 63 ignored
    chk_regs("R4");
    // R3 broken sequence: first byte then status read, then a new pair
    cmd_wr(8'h12); stat_rd(0, "R3");
    cmd_wr(8'h34); cmd_wr(8'h82);    // reg2 = 34 only if sequence restarted
    chk_regs("R3");
    cmd_wr(8'h56); data_rd();        // R3 latch returns first byte 56
    cmd_wr(8'h9A); cmd_wr(8'h83);
    chk_regs("R3");
    // R7 R8 R9 R10 flags
    pulse(1, 0, 0, 0);               // R10 irq high
    pulse(0, 1, 0, 5'd5);
    pulse(0, 1, 1, 5'd9);            // R9 number stays 5
    stat_rd(0, "R7");
    stat_rd(0, "R8");
    pulse(0, 1, 0, 5'd9);
    stat_rd(0, "R9");
    pulse(1, 0, 0, 0);
    stat_rd(1, "R8");                // pulse during read keeps frame
    stat_rd(0, "R8");
    cmd_wr(8'h00); cmd_wr(8'h81);    // irq disabled
    pulse(1, 0, 0, 0);               // R10 irq stays low
    stat_rd(0, "R10");
    // random mix
    for (int it = 0; it < 500; it++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: data_wr(8'($urandom));
        2, 3: data_rd();
        4:    begin cmd_wr(8'($urandom)); cmd_wr({2'b00, 6'($urandom)}); end
        5:    begin cmd_wr(8'($urandom)); cmd_wr({1'b0, 1'b1, 6'($urandom)}); end
        6:    begin cmd_wr(8'($urandom)); cmd_wr({2'b10, 6'($urandom)}); chk_regs("R4"); end
        7:    stat_rd(1'($urandom), "R8");
        8:    pulse(1'($urandom), 1'($urandom), 1'($urandom), 5'($urandom));
        default: cmd_wr(8'($urandom));
      endcase
    end
    chk_regs("R4");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule